// File: doc/BRIEF.md
# Pixel Stream Tagger with Frame and Row Markers

This block sits between a parallel image sensor and the write side of a byte queue. It works on the sensor clock. It turns each pixel into tagged 9-bit words and adds two kinds of control record to the stream. A frame header goes in before the first row of every frame. A row marker goes in before every row. Both records are written while the sensor is blanking, so they never collide with pixel traffic. Bit 8 of every word tells a later packetizer whether the low eight bits are control (1) or pixel payload (0).

The sensor marks a frame with `frame_valid` and a row with `line_valid`. A pixel word is taken only while both are high. The sensor holds each pixel on `pix` for two clocks, and the block spends those two clocks writing the pixel's two bytes.

The frame header is eight control bytes:
- a start code `0xF1`;
- a 16-bit frame count, low byte first;
- the configured row width in pixels, low byte first;
- the configured row count, low byte first;
- a zero byte.

The row marker is four control bytes: a code `0xE2`, the 16-bit row number with the low byte first, and a zero byte.

If the queue is full when a write is due, that word is lost, a sticky overflow flag is set, and the rest of the current row is discarded.

Top module: `pixel_stream_tagger`

## Requirements
- R1: After reset `q_wr` and `overflow` are 0. A `frame_valid` that is already high when reset is released does not start a frame; only a later 0-to-1 transition of `frame_valid` does.
- R2: A 0-to-1 transition of `frame_valid` sampled in cycle t makes `q_wr` high in cycles t+2 to t+9. Those eight words carry bit 8 = 1 and, in order, the bytes F1, count[7:0], count[15:8], LINE_PIX[7:0], LINE_PIX[15:8], LINES[7:0], LINES[15:8], 00.
- R3: The header of the first frame after reset carries frame count 0. Every emitted header increments the count by one, including the header of a frame that is later aborted.
- R4: Before the pixels of row n (n = 0 .. LINES-1) the block writes four words with bit 8 = 1: E2, n[7:0], n[15:8], 00. The marker for row 0 directly follows the frame header. The marker for row n+1 starts one cycle after `line_valid` falls at the end of row n.
- R5: Each pixel is written as two words with bit 8 = 0: first `pix[7:0]`, then the upper PIX_W-8 bits zero-extended to eight bits. Words appear one cycle after the sensor clock that sampled them.
- R6: Header and marker words are written only in blanking. The sensor must keep `line_valid` low for at least 14 cycles after `frame_valid` rises, and for at least 6 cycles between rows; under those limits no pixel word is lost or reordered.
- R7: Once LINES rows of a frame have been written, further `line_valid` pulses in that frame produce no writes. Nothing more is written until the next rising edge of `frame_valid`.
- R8: While `frame_valid` is low nothing is written. A frame whose `frame_valid` falls early is abandoned, and the next frame begins again with a full header.
- R9: A word that is due while `q_full` is high is not written, and `overflow` goes to 1. `overflow` stays 1 until reset.
- R10: After a pixel word is lost to `q_full`, no further pixel word of that row is written, even once `q_full` is low again. The next row's marker and pixels are written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | High for the duration of a frame |
| line_valid | input | 1 | High while a row's pixels are on `pix` |
| pix | input | PIX_W | Pixel value, held for two clocks per pixel |
| q_full | input | 1 | Queue cannot accept a word this cycle |
| q_wr | output | 1 | Write strobe to the queue |
| q_data | output | 9 | Bit 8 control flag, bits 7:0 byte |
| overflow | output | 1 | Sticky flag: a word was lost to `q_full` |

## Verification
The bench compares the full word stream of each frame against a stream it builds itself from random pixel values, row widths and blanking lengths. This catches a wrong header field, a byte order swap between the two pixel halves, a missing or misnumbered row marker, or a control flag set on pixel bytes.

Several directed frames go after the edge cases:
- Extra rows beyond LINES: a design that kept counting would emit surplus markers.
- An early drop of `frame_valid`: a design that resumed the old frame would skip the header or continue row numbering.
- `frame_valid` held high through reset: a design that treated level as start would emit a header with no real edge.
- A single-cycle `q_full` in mid-row: a design that only skipped one word would write the rest of the row, and a design whose flag was not sticky would lose the overflow report by the next frame.

// File: rtl/pixel_stream_tagger.sv
module pixel_stream_tagger #(
  parameter int PIX_W    = 10,
  parameter int LINE_PIX = 16,
  parameter int LINES    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic             line_valid,
  input  logic [PIX_W-1:0] pix,
  input  logic             q_full,
  output logic             q_wr,
  output logic [8:0]       q_data,
  output logic             overflow
);
  localparam int HI_W = PIX_W - 8;
  localparam logic [7:0] HDR_CODE = 8'hF1;
  localparam logic [7:0] ROW_CODE = 8'hE2;
  localparam logic [15:0] WID16  = 16'(LINE_PIX);
  localparam logic [15:0] ROWS16 = 16'(LINES);
  localparam logic [15:0] LAST_ROW = 16'(LINES - 1);

  typedef enum logic [2:0] {IDLE, FRAME_HDR, LINE_MARK, PIXELS, WAIT_LINE} st_t;

  st_t             st;
  logic [2:0]      idx;
  logic [15:0]     fcnt, rown;
  logic            phase, drop, fv_q;
  logic [HI_W-1:0] hi_q;
  logic            want;
  logic [8:0]      nb;

  always_comb begin
    want = 1'b0;
    nb   = 9'h000;
    case (st)
      FRAME_HDR: begin
        want = 1'b1;
        case (idx)
          3'd0:    nb = {1'b1, HDR_CODE};
          3'd1:    nb = {1'b1, fcnt[7:0]};
          3'd2:    nb = {1'b1, fcnt[15:8]};
          3'd3:    nb = {1'b1, WID16[7:0]};
          3'd4:    nb = {1'b1, WID16[15:8]};
          3'd5:    nb = {1'b1, ROWS16[7:0]};
          3'd6:    nb = {1'b1, ROWS16[15:8]};
          default: nb = {1'b1, 8'h00};
        endcase
      end
      LINE_MARK: begin
        want = 1'b1;
        case (idx)
          3'd0:    nb = {1'b1, ROW_CODE};
          3'd1:    nb = {1'b1, rown[7:0]};
          3'd2:    nb = {1'b1, rown[15:8]};
          default: nb = {1'b1, 8'h00};
        endcase
      end
      WAIT_LINE, PIXELS: begin
        want = line_valid && !drop;
        nb   = (st == PIXELS && phase) ? {1'b0, 8'(hi_q)} : {1'b0, pix[7:0]};
      end
      default: ;
    endcase
    want = want && frame_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; idx <= '0; fcnt <= '0; rown <= '0;
      phase <= 1'b0; drop <= 1'b0; fv_q <= 1'b1; hi_q <= '0;
      q_wr <= 1'b0; q_data <= '0; overflow <= 1'b0;
    end else begin
      fv_q   <= frame_valid;
      q_wr   <= want && !q_full;
      q_data <= nb;
      if (want && q_full) overflow <= 1'b1;
      if (!frame_valid) st <= IDLE;
      else case (st)
        IDLE: if (!fv_q) begin st <= FRAME_HDR; idx <= '0; end
        FRAME_HDR: begin
          idx <= idx + 3'd1;
          if (idx == 3'd7) begin
            st <= LINE_MARK; idx <= '0; rown <= '0; fcnt <= fcnt + 16'd1;
          end
        end
        LINE_MARK: begin
          idx <= idx + 3'd1;
          if (idx == 3'd3) begin st <= WAIT_LINE; phase <= 1'b0; drop <= 1'b0; end
        end
        WAIT_LINE: if (line_valid) begin
          st <= PIXELS; phase <= 1'b1; hi_q <= pix[PIX_W-1:8];
          if (q_full) drop <= 1'b1;
        end
        PIXELS: begin
          if (line_valid) begin
            phase <= ~phase;
            if (!phase) hi_q <= pix[PIX_W-1:8];
            if (want && q_full) drop <= 1'b1;
          end else if (rown == LAST_ROW) begin
            st <= IDLE;
          end else begin
            rown <= rown + 16'd1; st <= LINE_MARK; idx <= '0;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R9
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |=> !q_wr);
  // R8
  no_write_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> !q_wr);
  // R10
  row_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PIXELS && drop) |=> !q_wr);
  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && frame_valid && !fv_q) |=> (st == FRAME_HDR && idx == 3'd0));
  // R5
  pixel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PIXELS && frame_valid) |=> !q_data[8]);
endmodule

// File: tb/pixel_stream_tagger_tb.sv
module pixel_stream_tagger_tb;
  localparam int PIX_W = 10, LINE_PIX = 16, LINES = 4;

  logic clk = 1'b0, rst_n = 1'b0, frame_valid = 1'b0, line_valid = 1'b0, q_full = 1'b0;
  logic [PIX_W-1:0] pix = '0;
  logic q_wr, overflow;
  logic [8:0] q_data;

  int n_tests = 0, n_fail = 0;
  logic [8:0] exp_q[$], act_q[$];
  string tag_q[$];
  int fcnt_exp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pixel_stream_tagger #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .line_valid(line_valid),
    .pix(pix), .q_full(q_full), .q_wr(q_wr), .q_data(q_data), .overflow(overflow));

  always @(negedge clk) if (rst_n && q_wr) act_q.push_back(q_data);

  task automatic chk(bit ok, string req, int act, int exp, string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void push(logic [8:0] b, string t);
    exp_q.push_back(b); tag_q.push_back(t);
  endfunction

  function automatic void push_hdr();
    logic [15:0] f = 16'(fcnt_exp);
    push({1'b1, 8'hF1}, "R2"); push({1'b1, f[7:0]}, "R3"); push({1'b1, f[15:8]}, "R3");
    push({1'b1, 8'(LINE_PIX)}, "R2"); push({1'b1, 8'(LINE_PIX >> 8)}, "R2");
    push({1'b1, 8'(LINES)}, "R2"); push({1'b1, 8'(LINES >> 8)}, "R2");
    push({1'b1, 8'h00}, "R2");
    fcnt_exp++;
  endfunction

  function automatic void push_mark(int n);
    push({1'b1, 8'hE2}, "R4"); push({1'b1, 8'(n)}, "R4");
    push({1'b1, 8'(n >> 8)}, "R4"); push({1'b1, 8'h00}, "R4");
  endfunction

  task automatic run_frame(int nlines, int abort_at, int full_line, int full_byte);
    int vlead = 14 + int'($urandom % 7);
    push_hdr();
    @(negedge clk) frame_valid = 1'b1;
    repeat (vlead) @(negedge clk);
    for (int l = 0; l < nlines; l++) begin
      int w = 2 + int'($urandom % 5);
      int hb = 6 + int'($urandom % 7);
      bit dropping = 1'b0;
      if (l < LINES) push_mark(l);
      if (l == abort_at) break;
      for (int p = 0; p < w; p++) begin
        logic [PIX_W-1:0] pv = PIX_W'($urandom);
        for (int b = 0; b < 2; b++) begin
          line_valid = 1'b1; pix = pv;
          q_full = (l == full_line && 2*p + b == full_byte);
          if (q_full) dropping = 1'b1;
          if (l < LINES && !dropping)
            push(b == 0 ? {1'b0, pv[7:0]} : {1'b0, 8'(pv[PIX_W-1:8])}, "R5");
          @(negedge clk);
        end
      end
      line_valid = 1'b0; q_full = 1'b0; pix = '0;
      repeat (hb) @(negedge clk);
    end
    frame_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(string req);
    repeat (3) @(negedge clk);
    chk(act_q.size() == exp_q.size(), req, act_q.size(), exp_q.size(), "word count");
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      chk(act_q[i] === exp_q[i], tag_q[i], int'(act_q[i]), int'(exp_q[i]), $sformatf("word %0d", i));
    act_q.delete(); exp_q.delete(); tag_q.delete();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    frame_valid = 1'b1;                       // R1: level high through reset
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(q_wr == 1'b0, "R1", q_wr, 0, "wr after reset");
    chk(overflow == 1'b0, "R1", overflow, 0, "overflow after reset");
    repeat (30) @(negedge clk);
    chk(act_q.size() == 0, "R1", act_q.size(), 0, "writes without edge");
    frame_valid = 1'b0;
    repeat (3) @(negedge clk);

    for (int f = 0; f < 6; f++) begin          // R2 R3 R4 R5 R6 random frames
      run_frame(LINES, -1, -1, 0);
      compare("R6");
    end
    run_frame(LINES + 2, -1, -1, 0);           // R7: extra rows ignored
    compare("R7");
    run_frame(LINES, 2, -1, 0);                // R8: early abort
    compare("R8");
    run_frame(LINES, -1, -1, 0);               // R8: fresh header afterwards
    compare("R8");
    chk(overflow == 1'b0, "R9", overflow, 0, "overflow before full");
    run_frame(LINES, -1, 1, 3);                // R9 R10: full mid-row
    compare("R10");
    chk(overflow == 1'b1, "R9", overflow, 1, "overflow after full");
    run_frame(LINES, -1, 0, 0);                // R10: full on first byte of row
    compare("R10");
    run_frame(LINES, -1, -1, 0);
    compare("R9");
    chk(overflow == 1'b1, "R9", overflow, 1, "overflow sticky");
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule